// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a multiplier that sits on a simple register bus. Software loads a first operand through one of twelve first-operand addresses. The address it uses picks the operation: unsigned or signed, plain multiply or multiply-accumulate. The address also sets whether the first operand is 16 or 32 bits wide. Writing the second operand starts the calculation. The 64-bit result is read back as four 16-bit words, together with an extension word that flags overflow or carries the result's sign.

The core forms one 17×17 signed partial product per clock and adds it into the 64-bit result register. A 16×16 operation therefore takes one cycle, a mixed-width operation takes two, and a 32×32 operation takes four. The low half of a 32×32 result settles one cycle before the high half. Byte writes to operand registers let software use 8- and 24-bit operands; in signed modes the byte is sign-extended.

By default, a new second operand aborts any calculation in flight. When delayed-write mode is set, the bus is stalled instead until the running result is ready.

Top module: `mac_periph`

## Requirements
- R1: Addresses 0..3 load a 16-bit first operand. The two low address bits set the mode: bit 0 means signed and bit 1 means accumulate. An unsigned 16×16 product appears in the result words.
- R2: In a signed mode, operands are treated as two's complement and the 64-bit result is sign-extended.
- R3: Addresses 4..11 are low/high pairs: even addresses are low words and set the mode from (addr-4)>>1; odd addresses are high words. The first-operand width is set by the last first-operand address written: a high-word write makes it 32 bits, a later low-word write makes it 16 bits again, and the stored high word is then ignored.
- R4: The first operand and the mode persist, so writing only a new second operand reuses them.
- R5: A write to address 12 (16-bit second operand) starts an operation and clears both ready flags at the accepting edge. For a 16×16 operation, both flags are set by the next edge. For 32×32, lo_ready is set on the third edge after the start and hi_ready on the fourth. hi_ready never stands without lo_ready.
- R6: A write to address 13 loads the low word of a 32-bit second operand, and the next write to address 14 supplies the high word and starts the operation. A write to address 14 with no preceding write to address 13 changes nothing.
- R7: A byte write uses wdata[7:0]. It is sign-extended when the governing mode is signed and zero-extended otherwise. For the first-operand addresses 0..3 and the even addresses, the governing mode is the address's own mode; for all other operand addresses it is the current mode. A byte high word gives a 24-bit operand.
- R8: Accumulate modes add the new product to the 64-bit result; plain multiply modes replace it.
- R9: The extension word (address 20) behaves as follows. In unsigned modes it holds 1 once a carry leaves bit 63 and stays 1 through following accumulates; a plain unsigned multiply clears it. After a signed operation it holds 16 copies of result bit 63.
- R10: With delayed-write mode off, a write to address 12 or 13 during a calculation abandons it. A write to 13 leaves both ready flags low until the high word is written.
- R11: Address 15 holds configuration: bit 0 enables delayed writes and bit 1 selects low-half release. With delayed writes on, stall is high while a calculation runs, and writes are held off until it drops. Stall drops when the full result is ready. It drops as soon as the low half is ready only when low-half release is selected and the mode is not an accumulate mode.
- R12: A read registers its data one cycle after rd_en. Addresses 16..19 return result bits [15:0] up to [63:48], address 20 returns the extension word, address 15 returns the configuration, and other addresses return 0.
- R13: After reset, the result, extension word, ready flags and stall are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request, held until accepted |
| byte_wr | input | 1 | Write carries only wdata[7:0] |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Register read request |
| rdata | output | 16 | Registered read data |
| stall | output | 1 | Write cannot be accepted this cycle |
| lo_ready | output | 1 | Result bits [31:0] are final |
| hi_ready | output | 1 | Full 64-bit result is final |

## Verification
The assertions assume that a write is counted only in a cycle where wr_en is high and stall is low, and that addresses outside the map are never written. The stimulus therefore holds every write until stall drops and uses only mapped addresses. Whether a result is correct is judged by reading it through the bus after the ready flags rise. Back-to-back second-operand writes happen only in the abort scenario, where the assertions only claim that the flags clear.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int AW = 5;
  localparam logic [AW-1:0] AD_A16_LAST = 5'd3;
  localparam logic [AW-1:0] AD_A32_BASE = 5'd4;
  localparam logic [AW-1:0] AD_A32_LAST = 5'd11;
  localparam logic [AW-1:0] AD_B16      = 5'd12;
  localparam logic [AW-1:0] AD_BLO      = 5'd13;
  localparam logic [AW-1:0] AD_BHI      = 5'd14;
  localparam logic [AW-1:0] AD_CFG      = 5'd15;
  localparam logic [AW-1:0] AD_RES0     = 5'd16;
  localparam logic [AW-1:0] AD_EXT      = 5'd20;
  // mode bit 0: signed, bit 1: accumulate
  typedef logic [1:0] mode_t;
endpackage

// File: rtl/mac_opcap.sv
module mac_opcap
  import mac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          bsel,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  a_lo,
  output logic [W-1:0]  a_hi,
  output logic [W-1:0]  b_lo,
  output logic [W-1:0]  b_hi,
  output mode_t         mode,
  output logic          a_wide,
  output logic          pend,
  output logic          dly_en,
  output logic          lo_sel,
  output logic          go,
  output logic          go_bw,
  output logic          abort
);
  function automatic logic [W-1:0] fill(input logic [W-1:0] d, input logic sx, input logic b);
    return b ? {{(W-8){sx & d[7]}}, d[7:0]} : d;
  endfunction

  logic [AW-1:0] off;
  logic          is16, is32;
  mode_t         pair_mode;

  assign off       = addr - AD_A32_BASE;
  assign is16      = (addr <= AD_A16_LAST);
  assign is32      = (addr >= AD_A32_BASE) && (addr <= AD_A32_LAST);
  assign pair_mode = off[2:1];

  always_comb begin
    go    = wr && ((addr == AD_B16) || ((addr == AD_BHI) && pend));
    go_bw = (addr == AD_BHI);
    abort = wr && (addr == AD_BLO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_lo <= '0; a_hi <= '0; b_lo <= '0; b_hi <= '0;
      mode <= '0; a_wide <= 1'b0; pend <= 1'b0;
      dly_en <= 1'b0; lo_sel <= 1'b0;
    end else if (wr) begin
      if (is16) begin
        a_lo   <= fill(wdata, addr[0], bsel);
        mode   <= addr[1:0];
        a_wide <= 1'b0;
      end else if (is32 && !off[0]) begin
        a_lo   <= fill(wdata, pair_mode[0], bsel);
        mode   <= pair_mode;
        a_wide <= 1'b0;
      end else if (is32) begin
        a_hi   <= fill(wdata, mode[0], bsel);
        a_wide <= 1'b1;
      end else if (addr == AD_B16) begin
        b_lo <= fill(wdata, mode[0], bsel);
        pend <= 1'b0;
      end else if (addr == AD_BLO) begin
        b_lo <= fill(wdata, mode[0], bsel);
        pend <= 1'b1;
      end else if (addr == AD_BHI && pend) begin
        b_hi <= fill(wdata, mode[0], bsel);
        pend <= 1'b0;
      end else if (addr == AD_CFG) begin
        dly_en <= wdata[0];
        lo_sel <= wdata[1];
      end
    end
  end
endmodule

// File: rtl/mac_core.sv
module mac_core
  import mac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           go_bw,
  input  logic           abort,
  input  mode_t          mode,
  input  logic           a_wide,
  input  logic [W-1:0]   a_lo,
  input  logic [W-1:0]   a_hi,
  input  logic [W-1:0]   b_lo,
  input  logic [W-1:0]   b_hi,
  output logic [4*W-1:0] acc,
  output logic [W-1:0]   ext,
  output logic           busy,
  output logic           lo_rdy,
  output logic           hi_rdy,
  output logic           c_mac
);
  localparam int RW = 4 * W;

  logic              si, sj, c_sgn, c_aw, c_bw;
  logic [W-1:0]      da, db;
  logic signed [W:0] xa, xb;
  logic signed [2*W+1:0] pp;
  logic [RW-1:0]     ppx, pp_sh;
  logic [RW:0]       sum;
  logic              last, lo_now;

  always_comb begin
    da = si ? a_hi : a_lo;
    db = sj ? b_hi : b_lo;
    xa = {c_sgn & (si | ~c_aw) & da[W-1], da};
    xb = {c_sgn & (sj | ~c_bw) & db[W-1], db};
    pp = xa * xb;
    ppx = {{(RW-2*W-2){pp[2*W+1]}}, pp};
    case ({1'b0, si} + {1'b0, sj})
      2'd0:    pp_sh = ppx;
      2'd1:    pp_sh = ppx << W;
      default: pp_sh = ppx << (2 * W);
    endcase
    sum    = {1'b0, acc} + {1'b0, pp_sh};
    last   = (si == c_aw) && (sj == c_bw);
    lo_now = last || (c_aw && c_bw && !si && sj);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; ext <= '0; busy <= 1'b0; lo_rdy <= 1'b0; hi_rdy <= 1'b0;
      si <= 1'b0; sj <= 1'b0; c_sgn <= 1'b0; c_mac <= 1'b0;
      c_aw <= 1'b0; c_bw <= 1'b0;
    end else if (go) begin
      busy <= 1'b1; lo_rdy <= 1'b0; hi_rdy <= 1'b0;
      si <= 1'b0; sj <= 1'b0;
      c_sgn <= mode[0]; c_mac <= mode[1]; c_aw <= a_wide; c_bw <= go_bw;
      if (!mode[1]) begin
        acc <= '0;
        ext <= '0;
      end
    end else if (abort) begin
      busy <= 1'b0; lo_rdy <= 1'b0; hi_rdy <= 1'b0;
    end else if (busy) begin
      acc    <= sum[RW-1:0];
      lo_rdy <= lo_rdy | lo_now;
      if (!c_sgn && sum[RW]) ext <= {{(W-1){1'b0}}, 1'b1};
      if (last) begin
        busy   <= 1'b0;
        hi_rdy <= 1'b1;
        if (c_sgn) ext <= {W{sum[RW-1]}};
      end else if (si != c_aw) begin
        si <= 1'b1;
      end else begin
        si <= 1'b0;
        sj <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          byte_wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en,
  output logic [W-1:0]  rdata,
  output logic          stall,
  output logic          lo_ready,
  output logic          hi_ready
);
  logic [W-1:0]   a_lo, a_hi, b_lo, b_hi, ext;
  mode_t          mode;
  logic           a_wide, b_pend, dly_en, lo_sel, go, go_bw, abort;
  logic           core_busy, c_mac, wr_acc;
  logic [4*W-1:0] acc;
  logic [AW-1:0]  roff;

  assign stall  = dly_en & core_busy & ~(lo_sel & ~c_mac & lo_ready);
  assign wr_acc = wr_en & ~stall;
  assign roff   = addr - AD_RES0;

  mac_opcap #(.W(W)) u_opcap (
    .clk(clk), .rst(rst), .wr(wr_acc), .bsel(byte_wr), .addr(addr), .wdata(wdata),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi), .mode(mode), .a_wide(a_wide),
    .pend(b_pend), .dly_en(dly_en), .lo_sel(lo_sel), .go(go), .go_bw(go_bw), .abort(abort)
  );

  mac_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .go(go), .go_bw(go_bw), .abort(abort), .mode(mode),
    .a_wide(a_wide), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .acc(acc), .ext(ext), .busy(core_busy), .lo_rdy(lo_ready), .hi_rdy(hi_ready),
    .c_mac(c_mac)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr >= AD_RES0 && addr < AD_EXT) rdata <= acc[roff[1:0]*W +: W];
      else if (addr == AD_EXT)              rdata <= ext;
      else if (addr == AD_CFG)              rdata <= {{(W-2){1'b0}}, lo_sel, dly_en};
      else                                  rdata <= '0;
    end
  end
endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk
  import mac_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          stall,
  input logic          lo_ready,
  input logic          hi_ready,
  input logic          busy,
  input logic          pend
);
  logic acc_wr;
  assign acc_wr = wr_en && !stall;

  a_r5_start_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && addr == AD_B16) |=> (!lo_ready && !hi_ready));

  a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (rst)
    hi_ready |-> lo_ready);

  a_r11_stall_pending: assert property (@(posedge clk) disable iff (rst)
    stall |-> (busy && !hi_ready));

  a_r6_orphan_high: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && addr == AD_BHI && !pend && !busy) |=> !busy);

  a_r10_low_aborts: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && addr == AD_BLO) |=> (!busy && !hi_ready && !lo_ready));

  a_r13_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hi_ready && !lo_ready && !stall));
endmodule

bind mac_periph mac_periph_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .stall(stall),
  .lo_ready(lo_ready), .hi_ready(hi_ready), .busy(core_busy), .pend(b_pend)
);

// File: tb/mac_periph_test.sv
module mac_periph_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, byte_wr = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        stall, lo_ready, hi_ready;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  mac_periph uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .byte_wr(byte_wr), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .stall(stall), .lo_ready(lo_ready), .hi_ready(hi_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrw(input logic [4:0] a, input logic [15:0] d, input logic b, output int waits);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; byte_wr = b; waits = 0;
    while (stall) begin
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    wr_en = 1'b0; byte_wr = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    int w;
    wrw(a, d, 1'b0, w);
  endtask

  task automatic wrb(input logic [4:0] a, input logic [15:0] d);
    int w;
    wrw(a, d, 1'b1, w);
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_res(output logic [63:0] r);
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(5'(16 + i), v);
      r[i*16 +: 16] = v;
    end
  endtask

  task automatic t_reset;
    logic [63:0] r;
    logic [15:0] e;
    chk("R13 hi_ready", 64'(hi_ready), 0);
    chk("R13 lo_ready", 64'(lo_ready), 0);
    chk("R13 stall", 64'(stall), 0);
    rd_res(r);
    chk("R13 result", r, 0);
    rd(5'd20, e);
    chk("R13 ext", 64'(e), 0);
  endtask

  task automatic t_u16;
    logic [63:0] r;
    wr(5'd0, 16'hFFFF);
    wr(5'd12, 16'hFFFF);
    chk("R5 flags cleared at start", 64'({lo_ready, hi_ready}), 0);
    tick(1);
    chk("R5 flags after one cycle", 64'({lo_ready, hi_ready}), 64'd3);
    rd_res(r);
    chk("R1 unsigned 16x16", r, 64'hFFFF * 64'hFFFF);
  endtask

  task automatic t_s16;
    logic [63:0] r;
    wr(5'd1, 16'hFFFE);
    wr(5'd12, 16'h0003);
    tick(2);
    rd_res(r);
    chk("R2 signed 16x16", r, 64'(-64'sd6));
    wr(5'd12, 16'h0005);
    tick(2);
    rd_res(r);
    chk("R4 reuse first operand", r, 64'(-64'sd10));
  endtask

  task automatic t_w32;
    logic [63:0] r;
    wr(5'd6, 16'h0000);
    wr(5'd7, 16'h8000);
    wr(5'd13, 16'hFFFF);
    wr(5'd14, 16'hFFFF);
    tick(2);
    chk("R5 32x32 low not yet", 64'(lo_ready), 0);
    tick(1);
    chk("R5 32x32 low at third edge", 64'({lo_ready, hi_ready}), 64'd2);
    tick(1);
    chk("R5 32x32 high at fourth edge", 64'(hi_ready), 1);
    rd_res(r);
    chk("R3 R6 signed 32x32", r, 64'h0000_0000_8000_0000);
    wr(5'd5, 16'h1234);
    wr(5'd4, 16'h0003);
    wr(5'd12, 16'h0002);
    tick(3);
    rd_res(r);
    chk("R3 high then low gives 16-bit", r, 64'd6);
    wr(5'd4, 16'hFFFF);
    wr(5'd5, 16'hFFFF);
    wr(5'd12, 16'hFFFF);
    tick(3);
    rd_res(r);
    chk("R3 32x16 unsigned", r, 64'hFFFF_FFFF * 64'hFFFF);
  endtask

  task automatic t_bhi_ignored;
    logic [63:0] r;
    wr(5'd14, 16'h0007);
    tick(2);
    chk("R6 orphan high keeps flags", 64'({lo_ready, hi_ready}), 64'd3);
    rd_res(r);
    chk("R6 orphan high keeps result", r, 64'hFFFF_FFFF * 64'hFFFF);
  endtask

  task automatic t_byte;
    logic [63:0] r;
    wrb(5'd1, 16'h1280);
    wrb(5'd12, 16'h34FF);
    tick(2);
    rd_res(r);
    chk("R7 signed byte extension", r, 64'd128);
    wrb(5'd0, 16'h5580);
    wrb(5'd12, 16'h66FF);
    tick(2);
    rd_res(r);
    chk("R7 unsigned byte zero fill", r, 64'd32640);
    wr(5'd6, 16'h0000);
    wrb(5'd7, 16'hAAFF);
    wr(5'd12, 16'h0003);
    tick(3);
    rd_res(r);
    chk("R7 24-bit signed operand", r, 64'(-64'sd196608));
  endtask

  task automatic t_mac;
    logic [63:0] r;
    wr(5'd0, 16'd2);
    wr(5'd12, 16'd3);
    tick(2);
    wr(5'd2, 16'd4);
    wr(5'd12, 16'd5);
    tick(2);
    rd_res(r);
    chk("R8 accumulate", r, 64'd26);
    wr(5'd12, 16'd1);
    tick(2);
    rd_res(r);
    chk("R8 accumulate reuse", r, 64'd30);
  endtask

  task automatic t_carry;
    logic [63:0] r;
    logic [15:0] e;
    logic [64:0] dbl;
    dbl = {1'b0, 64'hFFFF_FFFE_0000_0001} + {1'b0, 64'hFFFF_FFFE_0000_0001};
    wr(5'd4, 16'hFFFF);
    wr(5'd5, 16'hFFFF);
    wr(5'd13, 16'hFFFF);
    wr(5'd14, 16'hFFFF);
    tick(5);
    rd(5'd20, e);
    chk("R9 unsigned multiply ext clear", 64'(e), 0);
    wr(5'd8, 16'hFFFF);
    wr(5'd9, 16'hFFFF);
    wr(5'd13, 16'hFFFF);
    wr(5'd14, 16'hFFFF);
    tick(5);
    rd_res(r);
    chk("R9 wrapped accumulate", r, dbl[63:0]);
    rd(5'd20, e);
    chk("R9 carry recorded", 64'(e), 1);
    wr(5'd12, 16'h0000);
    tick(3);
    rd(5'd20, e);
    chk("R9 carry sticky", 64'(e), 1);
    wr(5'd1, 16'hFFFE);
    wr(5'd12, 16'h0003);
    tick(2);
    rd(5'd20, e);
    chk("R9 signed sign word", 64'(e), 64'hFFFF);
  endtask

  task automatic t_abort;
    logic [63:0] r;
    wr(5'd4, 16'h0001);
    wr(5'd5, 16'h0001);
    wr(5'd13, 16'h0001);
    wr(5'd14, 16'h0001);
    wr(5'd12, 16'h0002);
    chk("R10 restart clears flags", 64'({lo_ready, hi_ready}), 0);
    tick(3);
    rd_res(r);
    chk("R10 restarted result", r, 64'h0002_0002);
    wr(5'd13, 16'h0001);
    wr(5'd14, 16'h0001);
    wr(5'd13, 16'h0003);
    tick(6);
    chk("R10 low write leaves flags low", 64'({lo_ready, hi_ready}), 0);
    wr(5'd14, 16'h0000);
    tick(5);
    rd_res(r);
    chk("R10 completed after abort", r, 64'h0003_0003);
  endtask

  task automatic t_dly;
    int w;
    wr(5'd15, 16'h0001);
    wr(5'd4, 16'hFFFF);
    wr(5'd5, 16'hFFFF);
    wr(5'd13, 16'hFFFF);
    wr(5'd14, 16'hFFFF);
    wrw(5'd15, 16'h0001, 1'b0, w);
    chk("R11 full-result wait cycles", 64'(w), 3);
    chk("R11 write held until ready", 64'(hi_ready), 1);
    wr(5'd15, 16'h0003);
    wr(5'd14, 16'h0000);
    wr(5'd13, 16'hFFFF);
    wr(5'd14, 16'hFFFF);
    wrw(5'd15, 16'h0003, 1'b0, w);
    chk("R11 low-half release", 64'(w), 2);
    tick(2);
    wr(5'd10, 16'h0001);
    wr(5'd11, 16'h0001);
    wr(5'd13, 16'h0001);
    wr(5'd14, 16'h0001);
    wrw(5'd15, 16'h0003, 1'b0, w);
    chk("R11 accumulate waits full", 64'(w), 3);
    wr(5'd15, 16'h0000);
    chk("R11 stall off", 64'(stall), 0);
  endtask

  task automatic t_read;
    logic [15:0] v;
    wr(5'd15, 16'h0002);
    rd(5'd15, v);
    chk("R12 config readback", 64'(v), 64'd2);
    tick(2);
    chk("R12 rdata holds", 64'(rdata), 64'd2);
    rd(5'd21, v);
    chk("R12 unmapped reads zero", 64'(v), 0);
    wr(5'd15, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_u16();
    t_s16();
    t_w32();
    t_bhi_ignored();
    t_byte();
    t_mac();
    t_carry();
    t_abort();
    t_dly();
    t_read();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule